// File: doc/BRIEF.md
# Register-Access SPI Slave

This block is the serial slave through which a host reaches a bank of 16-bit configuration registers, a read-only status word and a byte-wide data FIFO port. A system clock that runs at least four times faster than the serial clock oversamples the serial inputs. The serial clock, chip select and data input each pass through a two-flop synchronizer. Edge detection then drives the shifting, the command decode, and the single-cycle strobes toward the register bank and the FIFO.

Each chip-select frame opens with a command byte. The slave answers with a status byte while that byte comes in. Ordinary registers then move as whole 16-bit words, and the address steps forward after each complete word. The FIFO port address instead moves single bytes and keeps its address. Any word or byte that is cut short when chip select rises is discarded. The host samples MISO on falling edges of the serial clock, and the slave updates it after rising edges.

Top module: `spi_reg_slave`

## Requirements
- R1: The first byte of a frame is sent MSB first and is sampled on the falling edges of SCLK. Its bit 7 selects the direction (1 = read, 0 = write) and bits 6:0 give the starting address.
- R2: While the command byte is shifted in, MISO returns status_word[15:8], MSB first. Each bit becomes valid after a rising SCLK edge.
- R3: A register access moves 16 bits MSB first. Several words may follow one command byte, and the address increments by one after each complete word, wrapping from 127 to 0.
- R4: Addresses 32 to 35 are writable configuration registers. Each one takes the received word when its 16th bit completes, reads back the stored value, and is visible on cfg_q, with address 32 in bits 15:0.
- R5: Address 48 reads back status_word, and a write to it is ignored.
- R6: A read of any address other than 32 to 35, 48 and 50 returns 0x0000, and a write to such an address is ignored.
- R7: Address 50 is the FIFO port. It moves 8-bit units and its address never increments. Each completed written byte gives one fifo_push cycle carrying that byte. Each read byte shows fifo_rdata as it was at the start of the byte, and gives one fifo_pop cycle once the byte completes.
- R8: A word or byte that is incomplete when chip select rises is dropped. It causes no register write, no fifo_push and no fifo_pop.
- R9: spi_miso_oe is 1 while chip select is low. While chip select is high it equals bit 7 of the register at address 35.
- R10: fifo_push and fifo_pop are never high in the same cycle, and neither stays high for two consecutive cycles.
- R11: After reset, all configuration registers are zero, spi_miso_oe is 0, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| status_word | input | 16 | Status register contents; the upper byte is the status byte |
| fifo_push | output | 1 | One-cycle push strobe toward the FIFO |
| fifo_wdata | output | 8 | Byte that accompanies fifo_push |
| fifo_pop | output | 1 | One-cycle pop strobe toward the FIFO |
| fifo_rdata | input | 8 | Head byte of the FIFO (show-ahead) |
| cfg_q | output | REG_COUNT*16 (64) | Configuration register contents |

## Verification
Two events can land close together. The first is the write strobe for the last word of a frame. The second is the deselect that resets the frame logic. The bench raises chip select a few system clocks after the final falling edge, so the two meet, and it judges the outcome from cfg_q and from a later read back. In the same way, a full FIFO byte followed by a truncated one in the same frame must give exactly one push, and a scoreboard queue of expected bytes checks this. A partial read must leave the bench FIFO's pop count unchanged.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;

    localparam int ADDR_W = 7;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 7'd48;
    localparam logic [ADDR_W-1:0] FIFO_ADDR   = 7'd50;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } frame_phase_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic mosi;
        logic cs_n;
    } spi_evt_t;

    function automatic logic [4:0] unit_bits(frame_phase_e ph, logic [ADDR_W-1:0] a);
        if (ph == PH_CMD || a == FIFO_ADDR) return 5'd8;
        return 5'd16;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
`timescale 1ns/1ps
module spi_edge_sync
    import spi_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    always_comb begin
        evt.rise = sclk_p[STAGES-1] & ~sclk_d;
        evt.fall = ~sclk_p[STAGES-1] & sclk_d;
        evt.mosi = mosi_p[STAGES-1];
        evt.cs_n = cs_p[STAGES-1];
    end
endmodule

// File: rtl/spi_frame_ctl.sv
`timescale 1ns/1ps
module spi_frame_ctl
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic [7:0]        status_byte,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [BYTE_W-1:0] fifo_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              fifo_push,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    output logic              miso
);
    frame_phase_e      phase;
    cmd_t              cmd;
    logic [4:0]        bit_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_next;
    logic [WORD_W-1:0] load_val;
    logic              unit_done;
    logic              at_fifo;

    always_comb begin
        at_fifo   = (cmd.addr == FIFO_ADDR);
        rx_next   = {rx_sh[WORD_W-2:0], evt.mosi};
        unit_done = (bit_cnt == unit_bits(phase, cmd.addr) - 5'd1);
        if (phase == PH_CMD)  load_val = {status_byte, 8'h00};
        else if (at_fifo)     load_val = {fifo_rdata, 8'h00};
        else                  load_val = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            cmd        <= '0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            fifo_push  <= 1'b0;
            fifo_wdata <= '0;
            fifo_pop   <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            fifo_push <= 1'b0;
            fifo_pop  <= 1'b0;
            if (evt.cs_n) begin
                phase   <= PH_CMD;
                bit_cnt <= '0;
            end else begin
                if (evt.rise) begin
                    if (bit_cnt == 5'd0) tx_sh <= load_val;
                    else                 tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
                if (evt.fall) begin
                    rx_sh <= rx_next;
                    if (!unit_done) begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end else begin
                        bit_cnt <= '0;
                        if (phase == PH_CMD) begin
                            cmd   <= cmd_t'(rx_next[7:0]);
                            phase <= PH_DATA;
                        end else begin
                            if (cmd.rd) begin
                                fifo_pop <= at_fifo;
                            end else if (at_fifo) begin
                                fifo_push  <= 1'b1;
                                fifo_wdata <= rx_next[BYTE_W-1:0];
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= cmd.addr;
                                wr_data <= rx_next;
                            end
                            if (!at_fifo) cmd.addr <= cmd.addr + 7'd1;
                        end
                    end
                end
            end
        end
    end

    assign rd_addr = cmd.addr;
    assign miso    = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_cfg_bank.sv
`timescale 1ns/1ps
module spi_cfg_bank
    import spi_regs_pkg::*;
#(
    parameter int REG_BASE  = 32,
    parameter int REG_COUNT = 4,
    localparam int CFG_W    = REG_COUNT * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rd_word,
    output logic [CFG_W-1:0]  cfg_q
);
    logic [WORD_W-1:0] regs [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_BASE + g);
        always_ff @(posedge clk) begin
            if (rst)                              regs[g] <= '0;
            else if (wr_en && wr_addr == MY_ADDR) regs[g] <= wr_data;
        end
        assign cfg_q[g*WORD_W +: WORD_W] = regs[g];
    end

    always_comb begin
        rd_word = '0;
        if (rd_addr == STATUS_ADDR) rd_word = status_word;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_addr == ADDR_W'(REG_BASE + i)) rd_word = regs[i];
        end
    end
endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int REG_BASE    = 32,
    parameter int REG_COUNT   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int OPT_REG     = 3,
    parameter int OPT_BIT     = 7,
    localparam int CFG_W      = REG_COUNT * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [WORD_W-1:0] status_word,
    output logic              fifo_push,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    input  logic [BYTE_W-1:0] fifo_rdata,
    output logic [CFG_W-1:0]  cfg_q
);
    spi_evt_t          evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_en;
    logic [WORD_W-1:0] wr_data;
    logic [WORD_W-1:0] rd_word;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_frame_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .status_byte (status_word[WORD_W-1 -: 8]),
        .rd_word     (rd_word),
        .fifo_rdata  (fifo_rdata),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fifo_push   (fifo_push),
        .fifo_wdata  (fifo_wdata),
        .fifo_pop    (fifo_pop),
        .miso        (spi_miso)
    );

    spi_cfg_bank #(.REG_BASE(REG_BASE), .REG_COUNT(REG_COUNT)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .status_word (status_word),
        .rd_word     (rd_word),
        .cfg_q       (cfg_q)
    );

    assign spi_miso_oe = ~evt.cs_n | cfg_q[OPT_REG*WORD_W + OPT_BIT];
endmodule

// File: rtl/spi_reg_slave_chk.sv
`timescale 1ns/1ps
module spi_reg_slave_chk #(
    parameter int CFG_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             spi_cs_n,
    input logic             spi_miso_oe,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic [CFG_W-1:0] cfg_q
);
    assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_pop);

    assert_push_single_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_push |=> !fifo_push);

    assert_pop_single_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    assert_oe_selected_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(spi_cs_n, 2) |-> spi_miso_oe);

    assert_cfg_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
            |-> $stable(cfg_q));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.CFG_W(REG_COUNT*16)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .cfg_q       (cfg_q)
);

// File: tb/spi_reg_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_slave_bench;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [15:0] status_word = 16'h9E21;
    logic        fifo_push;
    logic [7:0]  fifo_wdata;
    logic        fifo_pop;
    logic [7:0]  fifo_rdata;
    logic [63:0] cfg_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] src_mem [8];
    logic [3:0] src_rd = '0;
    logic [3:0] src_wr = '0;

    assign fifo_rdata = src_mem[src_rd[2:0]];

    always #4 clk = ~clk;

    spi_reg_slave u_spi_reg_slave (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .status_word(status_word), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each push must match the next expected byte
    always @(posedge clk) begin
        if (!rst && fifo_push) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R8 unexpected push act=%h exp=none", fifo_wdata);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (fifo_wdata !== e) begin
                    bad++;
                    $display("FAIL R7 push data act=%h exp=%h", fifo_wdata, e);
                end
            end
        end
        if (!rst && fifo_pop) src_rd <= src_rd + 4'd1;
    end

    task automatic shift_bits(input logic [15:0] tx, input int n, output logic [15:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            spi_sclk = 1'b1;
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx = {rx[14:0], spi_miso};
            spi_sclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
        end
    endtask

    task automatic frame_start();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr_words(input logic [6:0] a, input logic [15:0] w [4], input int n);
        logic [15:0] r;
        frame_start();
        shift_bits({8'h00, 1'b0, a}, 8, r);
        for (int k = 0; k < n; k++) shift_bits(w[k], 16, r);
        frame_end();
    endtask

    task automatic rd_words(input logic [6:0] a, input int n,
                            output logic [15:0] w [4], output logic [7:0] st);
        logic [15:0] r;
        frame_start();
        shift_bits({8'h00, 1'b1, a}, 8, r);
        st = r[7:0];
        for (int k = 0; k < n; k++) begin
            shift_bits(16'h0000, 16, r);
            w[k] = r;
        end
        frame_end();
    endtask

    initial begin
        logic [15:0] w [4];
        logic [15:0] rv [4];
        logic [15:0] r;
        logic [7:0]  st;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 cfg", cfg_q, 64'h0);
        chk("R11 oe", {63'h0, spi_miso_oe}, 64'h0);
        chk("R11 strobes", {62'h0, fifo_push, fifo_pop}, 64'h0);

        // R1 R4 single write/read, R2 status byte
        w[0] = 16'hA5C3;
        wr_words(7'd32, w, 1);
        rd_words(7'd32, 1, rv, st);
        chk("R4 readback", {48'h0, rv[0]}, {48'h0, 16'hA5C3});
        chk("R2 status byte", {56'h0, st}, {56'h0, 8'h9E});

        // R3 multi-word write and read with auto-increment
        w[0] = 16'h1111; w[1] = 16'h2222; w[2] = 16'h3333; w[3] = 16'h0044;
        wr_words(7'd32, w, 4);
        chk("R3 cfg after burst", cfg_q, 64'h0044_3333_2222_1111);
        rd_words(7'd32, 4, rv, st);
        for (int k = 0; k < 4; k++) chk("R3 burst read", {48'h0, rv[k]}, {48'h0, w[k]});

        // R5 R6 read across unimplemented and status addresses
        rd_words(7'd47, 3, rv, st);
        chk("R6 unimpl read 47", {48'h0, rv[0]}, 64'h0);
        chk("R5 status read 48", {48'h0, rv[1]}, {48'h0, 16'h9E21});
        chk("R6 unimpl read 49", {48'h0, rv[2]}, 64'h0);

        // R5 R6 writes ignored
        w[0] = 16'hFFFF;
        wr_words(7'd48, w, 1);
        w[0] = 16'hBEEF;
        wr_words(7'd40, w, 1);
        chk("R6 cfg unchanged", cfg_q, 64'h0044_3333_2222_1111);
        rd_words(7'd48, 1, rv, st);
        chk("R5 status after write", {48'h0, rv[0]}, {48'h0, 16'h9E21});

        // R9 MISO output enable
        chk("R9 deselected oe off", {63'h0, spi_miso_oe}, 64'h0);
        frame_start();
        chk("R9 selected oe on", {63'h0, spi_miso_oe}, 64'h1);
        frame_end();
        w[0] = 16'h0080;
        wr_words(7'd35, w, 1);
        chk("R9 option keeps oe", {63'h0, spi_miso_oe}, 64'h1);
        w[0] = 16'h0044;
        wr_words(7'd35, w, 1);
        chk("R9 option cleared", {63'h0, spi_miso_oe}, 64'h0);

        // R7 FIFO write: three bytes, no address increment
        exp_q.push_back(8'h5A); exp_q.push_back(8'hC3); exp_q.push_back(8'h7E);
        frame_start();
        shift_bits(16'h0032, 8, r);
        shift_bits(16'h005A, 8, r);
        shift_bits(16'h00C3, 8, r);
        shift_bits(16'h007E, 8, r);
        frame_end();
        chk("R7 all pushes seen", exp_q.size(), 0);

        // R7 FIFO read: bytes come from head, one pop each
        src_mem[0] = 8'h11; src_mem[1] = 8'h22; src_mem[2] = 8'h33; src_wr = 4'd3;
        frame_start();
        shift_bits(16'h00B2, 8, r);
        shift_bits(16'h0000, 8, r); chk("R7 read byte0", {56'h0, r[7:0]}, 64'h11);
        shift_bits(16'h0000, 8, r); chk("R7 read byte1", {56'h0, r[7:0]}, 64'h22);
        shift_bits(16'h0000, 8, r); chk("R7 read byte2", {56'h0, r[7:0]}, 64'h33);
        frame_end();
        chk("R7 pop count", {60'h0, src_rd}, 64'h3);

        // R8 partial register word discarded
        frame_start();
        shift_bits(16'h0021, 8, r);
        shift_bits(16'hFFFF, 10, r);
        frame_end();
        chk("R8 partial word", cfg_q, 64'h0044_3333_2222_1111);

        // R8 full byte then partial byte to FIFO: exactly one push
        exp_q.push_back(8'h99);
        frame_start();
        shift_bits(16'h0032, 8, r);
        shift_bits(16'h0099, 8, r);
        shift_bits(16'h001F, 5, r);
        frame_end();
        chk("R8 one push only", exp_q.size(), 0);

        // R8 partial FIFO read: no pop
        src_mem[3] = 8'h4C; src_wr = 4'd4;
        frame_start();
        shift_bits(16'h00B2, 8, r);
        shift_bits(16'h0000, 4, r);
        frame_end();
        chk("R8 partial read bits", {60'h0, r[3:0]}, 64'h4);
        chk("R8 no pop on partial", {60'h0, src_rd}, 64'h3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule